// File: doc/BRIEF.md
# Status Alert Mask Bank

This block stores one 8-bit mask for each of seven status registers and uses those masks to decide which live status conditions drive an active-low alert line. An upstream management-bus slave has already decoded each transaction. That slave presents two kinds of request. A mask write carries a target status code and a new mask byte. A mask read carries a target status code and gets back one mask byte.

A mask bit of 0 lets the matching status bit pull the alert low. A mask bit of 1 blocks it. Masking never changes the status bits themselves, which arrive on a flat input bus from the status latches outside this block. Some mask positions are fixed: they always hold 1, ignore writes, and can never let their status bit raise the alert. A request that names an unsupported status code gets an invalid-data pulse together with its completion strobe.

Top module: `alert_mask_bank`

## Requirements
- R1: After reset, every mask reads back as its fixed pattern: ones in the fixed positions and zeros in the writable ones. With all status bits at 0, alertN is 1.
- R2: Codes 7Ah to 80h map in order to mask index 0 to 6. Index 0 is output voltage, 1 output current, 2 input, 3 temperature, 4 communication, 5 other and 6 manufacturer.
- R3: The fixed-position patterns, by index from 0 to 6, are 07h, 4Fh, 77h, 3Fh, 0Dh, FEh and 0Ch. In each pattern a 1 marks a fixed bit.
- R4: A write to a supported code stores the writable bits of the mask byte. A later read of that code returns the written byte OR the fixed pattern.
- R5: Writing 0 or 1 into a fixed position is ignored. The position still reads 1, and the write raises no invalid-data pulse.
- R6: Every request (write or read) produces a done pulse exactly one clock later. A read returns its data in that same cycle. When done is low, rdData is 00h.
- R7: A request with a code outside 7Ah to 80h raises badCode in its done cycle and changes no mask. For a read, rdData is 00h in that cycle. badCode is never high without done.
- R8: alertN is registered. One clock after the inputs, it is 0 exactly when some status bit is 1 and its mask bit is 0, taken over all seven registers. Status bit j of index i sits at statusBits[8*i+j].
- R9: A status bit whose mask bit is 1 never pulls the alert low. Fixed positions never pull it low either.
- R10: A mask write acts on the alert with no commit step. For a write sampled at clock edge k, the new mask first shows on alertN after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Mask write request, one cycle |
| wrCode | input | 8 | Target status code for the write |
| wrMask | input | 8 | Mask byte for the write |
| rdValid | input | 1 | Mask read request, one cycle |
| rdCode | input | 8 | Target status code for the read |
| statusBits | input | 56 | Live status bits, 8 per supported register, index 0 lowest |
| done | output | 1 | Request completion strobe |
| badCode | output | 1 | Invalid-data pulse for an unsupported code |
| rdData | output | 8 | Mask byte returned by a read |
| alertN | output | 1 | Active-low alert |

## Verification
The assertions assume that the upstream slave never raises wrValid and rdValid in the same cycle. The design does give writes priority if that happens, but the assertions only cover the exclusive case. The assertions also assume that the status bus settles before a clock edge. The bench keeps to both assumptions: it drives every request from a single task that raises one valid signal for one cycle, and it changes statusBits only on falling clock edges. Requests are always separated by at least one idle cycle, so each done pulse can be matched to exactly one request.

// File: rtl/amb_pkg.sv
package amb_pkg;
  localparam int BYTE_W   = 8;
  localparam int NREG_DEF = 7;
  localparam int IDX_W    = 3;

  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic              bad;
    logic [IDX_W-1:0]  idx;
  } ctrlStrobe_t;

  // Positions held at 1: unimplemented mask bits for each supported register.
  function automatic logic [BYTE_W-1:0] fixedMask(input int idx);
    case (idx)
      0:       fixedMask = 8'h07;
      1:       fixedMask = 8'h4F;
      2:       fixedMask = 8'h77;
      3:       fixedMask = 8'h3F;
      4:       fixedMask = 8'h0D;
      5:       fixedMask = 8'hFE;
      6:       fixedMask = 8'h0C;
      default: fixedMask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/amb_ctrl.sv
module amb_ctrl
  import amb_pkg::*;
#(
  parameter int          NREG     = NREG_DEF,
  parameter logic [7:0]  BASE_CODE = 8'h7A
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [7:0]  wrCode,
  input  logic        rdValid,
  input  logic [7:0]  rdCode,
  output ctrlStrobe_t strobe,
  output logic        done,
  output logic        badCode
);
  localparam logic [7:0] NREG_B = 8'(NREG);

  logic [7:0] reqCode;
  logic [7:0] offset;
  logic       inRange;
  logic       anyReq;

  always_comb begin
    anyReq      = wrValid | rdValid;
    reqCode     = wrValid ? wrCode : rdCode;
    offset      = reqCode - BASE_CODE;
    inRange     = (offset < NREG_B);
    strobe.wrEn = wrValid & inRange;
    strobe.rdEn = rdValid & ~wrValid & inRange;
    strobe.bad  = anyReq & ~inRange;
    strobe.idx  = offset[IDX_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done    <= 1'b0;
      badCode <= 1'b0;
    end else begin
      done    <= anyReq;
      badCode <= strobe.bad;
    end
  end
endmodule

// File: rtl/amb_datapath.sv
module amb_datapath
  import amb_pkg::*;
#(
  parameter int NREG = NREG_DEF
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic [BYTE_W-1:0]      wrMask,
  input  logic [NREG*BYTE_W-1:0] statusBits,
  output logic [BYTE_W-1:0]      rdData,
  output logic                   alertN
);
  logic [BYTE_W-1:0] maskQ [NREG];
  logic [NREG-1:0]   regHit;
  logic [BYTE_W-1:0] rdSel;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [BYTE_W-1:0] FIX = fixedMask(g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        maskQ[g] <= FIX;
      else if (strobe.wrEn && (int'(strobe.idx) == g))
        maskQ[g] <= wrMask | FIX;
    end
    assign regHit[g] = |(statusBits[g*BYTE_W +: BYTE_W] & ~maskQ[g]);
  end

  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NREG; i++)
      if (int'(strobe.idx) == i) rdSel = maskQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      alertN <= 1'b1;
    end else begin
      rdData <= strobe.rdEn ? rdSel : '0;
      alertN <= ~|regHit;
    end
  end
endmodule

// File: rtl/alert_mask_bank.sv
module alert_mask_bank
  import amb_pkg::*;
#(
  parameter int          NREG      = NREG_DEF,
  parameter logic [7:0]  BASE_CODE = 8'h7A
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrValid,
  input  logic [7:0]             wrCode,
  input  logic [7:0]             wrMask,
  input  logic                   rdValid,
  input  logic [7:0]             rdCode,
  input  logic [NREG*BYTE_W-1:0] statusBits,
  output logic                   done,
  output logic                   badCode,
  output logic [7:0]             rdData,
  output logic                   alertN
);
  ctrlStrobe_t strobe;

  amb_ctrl #(.NREG(NREG), .BASE_CODE(BASE_CODE)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrCode(wrCode),
    .rdValid(rdValid), .rdCode(rdCode),
    .strobe(strobe), .done(done), .badCode(badCode)
  );

  amb_datapath #(.NREG(NREG)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .wrMask(wrMask),
    .statusBits(statusBits),
    .rdData(rdData), .alertN(alertN)
  );
endmodule

// File: rtl/amb_checker.sv
module amb_checker #(
  parameter int NREG = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrValid,
  input logic              rdValid,
  input logic [7:0]        rdCode,
  input logic [NREG*8-1:0] statusBits,
  input logic              done,
  input logic              badCode,
  input logic [7:0]        rdData,
  input logic              alertN
);
  // Input assumption: one request kind per cycle.
  p_one_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid && rdValid));

  p_done_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid || rdValid) |=> done);

  p_no_spurious_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrValid || rdValid) |=> !done);

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> (rdData == 8'h00));

  p_bad_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    badCode |-> (done && rdData == 8'h00));

  p_quiet_alert_r8: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits == '0) |=> alertN);

  p_fixed_ones_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !wrValid && rdCode == 8'h7F) |=> (rdData[7:1] == 7'h7F));

  p_fixed_status_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusBits[5*8+7 -: 7] != '0 && statusBits[5*8] == 1'b0 &&
     statusBits[0 +: 5*8] == '0 && statusBits[6*8 +: 8] == '0) |=> alertN);
endmodule

bind alert_mask_bank amb_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdValid(rdValid),
  .rdCode(rdCode), .statusBits(statusBits), .done(done),
  .badCode(badCode), .rdData(rdData), .alertN(alertN)
);

// File: tb/sim_alert_mask_bank.sv
`timescale 1ns/1ps
module sim_alert_mask_bank;
  localparam int NREG = 7;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [7:0]        wrCode = '0;
  logic [7:0]        wrMask = '0;
  logic              rdValid = 1'b0;
  logic [7:0]        rdCode = '0;
  logic [NREG*8-1:0] statusBits = '0;
  logic              done, badCode, alertN;
  logic [7:0]        rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  alert_mask_bank u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrCode(wrCode),
    .wrMask(wrMask), .rdValid(rdValid), .rdCode(rdCode),
    .statusBits(statusBits), .done(done), .badCode(badCode),
    .rdData(rdData), .alertN(alertN)
  );

  function automatic logic [7:0] expFix(input int i);
    case (i)
      0: return 8'h07; 1: return 8'h4F; 2: return 8'h77; 3: return 8'h3F;
      4: return 8'h0D; 5: return 8'hFE; 6: return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one request at a falling edge and sample its done cycle.
  task automatic request(input bit isWr, input logic [7:0] code, input logic [7:0] m,
                         output bit d, output bit b, output logic [7:0] q);
    @(negedge clk);
    if (isWr) begin wrValid = 1'b1; wrCode = code; wrMask = m; end
    else      begin rdValid = 1'b1; rdCode = code; end
    @(negedge clk);
    wrValid = 1'b0; rdValid = 1'b0;
    d = done; b = badCode; q = rdData;
  endtask

  task automatic readMask(input int i, output logic [7:0] q);
    bit d, b;
    request(1'b0, 8'h7A + 8'(i), 8'h00, d, b, q);
  endtask

  task automatic writeMask(input int i, input logic [7:0] m);
    bit d, b; logic [7:0] q;
    request(1'b1, 8'h7A + 8'(i), m, d, b, q);
    check(d && !b, "R5", {d, b}, 2'b10);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit d, b;
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(alertN === 1'b1 && done === 1'b0, "R1", alertN, 1);

    // R1 / R2 / R3: reset contents through the read path
    for (int i = 0; i < NREG; i++) begin
      readMask(i, q);
      check(q === expFix(i), "R1", q, expFix(i));
    end

    // R7 / R6: sweep every read code
    for (int c = 0; c < 256; c++) begin
      bit sup;
      sup = (c >= 8'h7A && c <= 8'h80);
      request(1'b0, 8'(c), 8'h00, d, b, q);
      check(d === 1'b1, "R6", d, 1);
      check(b === !sup, "R7", b, !sup);
      if (sup) check(q === expFix(c - 8'h7A), "R2", q, expFix(c - 8'h7A));
      else     check(q === 8'h00, "R7", q, 0);
    end

    // R4 / R5: every mask byte on every register
    for (int i = 0; i < NREG; i++)
      for (int v = 0; v < 256; v++) begin
        writeMask(i, 8'(v));
        readMask(i, q);
        check(q === (8'(v) | expFix(i)), "R4", q, 8'(v) | expFix(i));
      end

    // R7: unsupported writes change nothing
    for (int i = 0; i < NREG; i++) writeMask(i, 8'h00);
    for (int c = 0; c < 256; c++) begin
      if (c >= 8'h7A && c <= 8'h80) continue;
      request(1'b1, 8'(c), 8'hFF, d, b, q);
      check(d && b, "R7", {d, b}, 2'b11);
    end
    for (int i = 0; i < NREG; i++) begin
      readMask(i, q);
      check(q === expFix(i), "R7", q, expFix(i));
    end

    // R8 / R9: single status bits against open and closed masks
    for (int i = 0; i < NREG; i++)
      for (int j = 0; j < 8; j++) begin
        bit fixedBit;
        fixedBit = expFix(i)[j];
        @(negedge clk);
        statusBits = '0;
        statusBits[8*i + j] = 1'b1;
        @(negedge clk);
        check(alertN === fixedBit, fixedBit ? "R9" : "R8", alertN, fixedBit);
        writeMask(i, 8'hFF);
        @(negedge clk);
        check(alertN === 1'b1, "R9", alertN, 1);
        writeMask(i, 8'h00);
        @(negedge clk);
        statusBits = '0;
        @(negedge clk);
        check(alertN === 1'b1, "R8", alertN, 1);
      end

    // R8: OR across registers
    @(negedge clk);
    statusBits = '0;
    statusBits[8*0 + 7] = 1'b1;
    statusBits[8*4 + 6] = 1'b1;
    writeMask(0, 8'h80);
    @(negedge clk);
    check(alertN === 1'b0, "R8", alertN, 0);
    writeMask(4, 8'h40);
    @(negedge clk);
    check(alertN === 1'b1, "R8", alertN, 1);

    // R10: a write lands on the alert one edge after the mask changes
    writeMask(0, 8'h00);
    writeMask(4, 8'h00);
    @(negedge clk);
    statusBits = '0;
    statusBits[8*2 + 3] = 1'b1;
    @(negedge clk);
    check(alertN === 1'b0, "R10", alertN, 0);
    wrValid = 1'b1; wrCode = 8'h7C; wrMask = 8'h08;
    @(negedge clk);
    wrValid = 1'b0;
    check(alertN === 1'b0, "R10", alertN, 0);
    @(negedge clk);
    check(alertN === 1'b1, "R10", alertN, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule